// File: doc/BRIEF.md
# Asynchronous Memory Read Controller

This block is a bus master that reads from an external asynchronous memory. It runs entirely on one system clock. On the internal side, a requester presents an address and a configuration word with a valid/ready handshake. The block then runs one read bus cycle on the memory side, with an address, an active-low select and an active-low read strobe. It returns the word it captured as a one-cycle valid pulse with the data.

The configuration word holds four 5-bit cycle counts. Three of them shape the read cycle:
- a wait-state count sets the strobe width;
- a read-hold count keeps the address and select driven after the strobe;
- an idle count sets a turnaround gap before the next access.

The fourth count, the hold count, belongs to write cycles and is not used for reads. The memory can stretch the strobe by pulling its acknowledge input low. That input passes through a two-flop synchronizer before the controller looks at it.

The controller is a state machine with five states:
- IDLE: ready is high. A valid request moves it to SETUP.
- SETUP: address and select are driven for one cycle. It always moves to STROBE.
- STROBE: the read strobe is low. It leaves once the wait count is exhausted and the synchronized acknowledge is high. It goes to HOLD if the read-hold count is non-zero, otherwise to TURNAROUND if the idle count is non-zero, otherwise to IDLE.
- HOLD: address and select stay driven. When the count ends it goes to TURNAROUND if the idle count is non-zero, otherwise to IDLE.
- TURNAROUND: bus released. When the count ends it goes to IDLE.

Top module: `amr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, req_ready is 1, mem_sel_n and mem_rd_n are 1 and rd_valid is 0.
- R2: A request is taken only at a clock edge where req_valid and req_ready are both 1, and req_ready is 1 only while no bus cycle is in progress (select high).
- R3: mem_addr carries the accepted address and mem_sel_n is low for exactly one clock cycle before mem_rd_n falls.
- R4: With acknowledge high, mem_rd_n stays low for exactly W cycles, where W is cfg_word bits 4:0. A value of 0 gives one cycle.
- R5: mem_ack is synchronized through two flops. While the synchronized value is low, the strobe does not rise. If acknowledge goes high after the strobe fell, the strobe rises at the second clock edge after the first edge that samples it high, or after W cycles, whichever is later.
- R6: mem_data is captured at the clock edge where mem_rd_n rises. In the following cycle, rd_valid is 1 for exactly one cycle with rd_data equal to the captured word.
- R7: After mem_rd_n rises, mem_sel_n and mem_addr stay driven for exactly H cycles, where H is cfg_word bits 9:5.
- R8: The next falling edge of mem_rd_n comes no sooner than H + I + 1 cycles after the previous rising edge, where I is cfg_word bits 14:10.
- R9: cfg_word bits 19:15 (the write hold count) have no effect on read timing or data.
- R10: The address and configuration are latched when the request is accepted. Changes on req_addr or cfg_word during the access have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | AW | Address of the requested read |
| cfg_word | input | 20 | Wait [4:0], read hold [9:5], idle [14:10], write hold [19:15] |
| rd_valid | output | 1 | One-cycle pulse marking returned data |
| rd_data | output | DW | Captured read data |
| mem_addr | output | AW | External memory address |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_data | input | DW | Read data from memory |
| mem_ack | input | 1 | Memory acknowledge, low extends the strobe |

## Verification
The assertions assume the following about the inputs:
- mem_data is stable in the cycle before the strobe rises.
- mem_ack changes at most once per strobe in the tested scenarios, so the acknowledge-stretch behaviour is well defined.
- req_valid is only meaningful at the edge where ready is high.

The stimulus stays within these limits:
- The memory model drives data derived from the current address only while the strobe is low, and a junk word otherwise.
- Acknowledge is lowered only while the bus is idle and settled through the synchronizer. It is raised once, a counted number of cycles after the strobe falls.
- Requests are held for exactly one accepting edge. Address and configuration are scrambled right after it.

// File: rtl/amr_pkg.sv
package amr_pkg;

    localparam int CNT_W = 5;
    localparam int CFG_W = 4 * CNT_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } amr_state_t;

    // Field order fixes the bit positions: wst occupies the LSBs.
    typedef struct packed {
        logic [CNT_W-1:0] whold;
        logic [CNT_W-1:0] idle;
        logic [CNT_W-1:0] rhold;
        logic [CNT_W-1:0] wst;
    } amr_cfg_t;

endpackage

// File: rtl/amr_ack_sync.sv
module amr_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/amr_down_cnt.sv
module amr_down_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/amr_ctrl.sv
module amr_ctrl
    import amr_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [CFG_W-1:0] cfg_word,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_rd_n,
    input  logic [DW-1:0] mem_data,
    input  logic          mem_ack
);

    amr_state_t state_q, state_d;
    amr_cfg_t   cfg_q;
    logic [AW-1:0] addr_q;
    logic       ack_s;
    logic       cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic       cnt_zero;
    logic       accept;
    logic       strobe_end;

    amr_ack_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mem_ack),
        .sync_out (ack_s)
    );

    amr_down_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign strobe_end = (state_q == ST_STROBE) && (state_d != ST_STROBE);

    // Next-state and counter load decisions
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                state_d  = ST_STROBE;
                cnt_load = 1'b1;
                cnt_val  = (cfg_q.wst == '0) ? '0 : CNT_W'(cfg_q.wst - 1'b1);
            end
            ST_STROBE: begin
                if (cnt_zero && ack_s) begin
                    if (cfg_q.rhold != '0) begin
                        state_d  = ST_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(cfg_q.rhold - 1'b1);
                    end else if (cfg_q.idle != '0) begin
                        state_d  = ST_TURN;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(cfg_q.idle - 1'b1);
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    if (cfg_q.idle != '0) begin
                        state_d  = ST_TURN;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(cfg_q.idle - 1'b1);
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_TURN: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cfg_q  <= amr_cfg_t'(cfg_word);
                addr_q <= req_addr;
            end
        end
    end

    // Data capture at the strobe's rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= strobe_end;
            if (strobe_end) rd_data <= mem_data;
        end
    end

    // Bus outputs decoded from state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_sel_n = !((state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                      (state_q == ST_HOLD));
        mem_rd_n  = (state_q != ST_STROBE);
        mem_addr  = addr_q;
    end

    // ---------------- assertions ----------------
    logic       chk_rd_prev;
    logic [7:0] chk_w;
    logic [7:0] chk_gap;
    logic [7:0] chk_min;
    logic       chk_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_rd_prev <= 1'b1;
            chk_w       <= '0;
            chk_gap     <= '0;
            chk_min     <= '0;
            chk_seen    <= 1'b0;
        end else begin
            chk_rd_prev <= mem_rd_n;
            if (!mem_rd_n) chk_w <= (chk_w == 8'hFF) ? chk_w : chk_w + 1'b1;
            else           chk_w <= '0;
            if (mem_rd_n && !chk_rd_prev) begin
                chk_gap  <= 8'd1;
                chk_seen <= 1'b1;
                chk_min  <= 8'(cfg_q.rhold) + 8'(cfg_q.idle) + 8'd1;
            end else if (mem_rd_n && chk_gap != 8'hFF) begin
                chk_gap  <= chk_gap + 1'b1;
            end
        end
    end

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (!mem_sel_n && mem_rd_n));

    a_r3_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_n) |-> ($past(!mem_sel_n) && $past(mem_addr) == mem_addr));

    a_r4_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_n && !chk_rd_prev) |->
            (chk_w >= ((cfg_q.wst == '0) ? 8'd1 : 8'(cfg_q.wst))));

    a_r5_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && !ack_s) |=> (state_q == ST_STROBE));

    a_r6_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |-> rd_valid);

    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_rd_n) && cfg_q.rhold != '0) |-> !mem_sel_n);

    a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && chk_rd_prev && chk_seen) |-> (chk_gap >= chk_min));

endmodule

// File: tb/amr_ctrl_test.sv
module amr_ctrl_test;

    localparam int AW = 24;
    localparam int DW = 32;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int w;
        int rh;
        int ic;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [19:0]   cfg_word = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n;
    logic          mem_rd_n;
    logic [DW-1:0] mem_data;
    logic          mem_ack = 1'b1;

    int errors = 0;
    int checks = 0;
    item_t q[$];
    int phase = 0;
    bit done = 0;

    always #4 clk = ~clk;

    amr_ctrl #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .cfg_word(cfg_word), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_rd_n(mem_rd_n), .mem_data(mem_data), .mem_ack(mem_ack)
    );

    function automatic logic [DW-1:0] data_of(logic [AW-1:0] a);
        return {a[7:0], a} ^ 32'h5A5A_0F0F;
    endfunction

    assign mem_data = (!mem_rd_n) ? data_of(mem_addr) : 32'hDEAD_BEEF;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: issues one read and pushes the expected outcome
    task automatic do_read(logic [AW-1:0] a, int w, int rh, int ic, int hold, int ack_k);
        int weff;
        weff = (w == 0) ? 1 : w;
        if (ack_k >= 0) begin
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            mem_ack = 1'b0;
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        cfg_word  = {5'(hold), 5'(ic), 5'(rh), 5'(w)};
        q.push_back('{a: a, d: data_of(a),
                      w: (ack_k < 0) ? weff : ((ack_k + 3 > weff) ? ack_k + 3 : weff),
                      rh: rh, ic: ic});
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        cfg_word  = 20'hFFFFF;
        if (ack_k >= 0) begin
            @(negedge clk);
            while (mem_rd_n) @(negedge clk);
            repeat (ack_k) @(negedge clk);
            mem_ack = 1'b1;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        item_t cur;
        int setup_n = 0, width = 0, hold_n = 0, since = 0;
        int prev_min = 0;
        bit have_prev = 0;
        bit rise_now;
        cur = '{a: '0, d: '0, w: 0, rh: 0, ic: 0};
        forever begin
            @(negedge clk);
            rise_now = 0;
            if (rst_n) begin
                if (!mem_sel_n && req_ready) begin
                    errors++;
                    $display("FAIL R2 ready during access: actual=1 expected=0");
                end
                unique case (phase)
                    0: begin
                        if (!mem_sel_n) begin
                            if (q.size() == 0) begin
                                errors++;
                                $display("FAIL R2 unrequested access: actual=1 expected=0");
                            end else cur = q.pop_front();
                            setup_n = 1;
                            phase = 1;
                            check(mem_rd_n, "R3", "strobe low with select", 0, 1);
                        end
                        if (have_prev) since++;
                    end
                    1: begin
                        if (!mem_rd_n) begin
                            check(setup_n == 1, "R3", "setup cycles", setup_n, 1);
                            check(mem_addr == cur.a, "R10", "latched address", int'(mem_addr), int'(cur.a));
                            if (have_prev)
                                check(since >= prev_min, "R8", "turnaround gap", since, prev_min);
                            width = 1;
                            phase = 2;
                        end else begin
                            setup_n++;
                            if (have_prev) since++;
                        end
                    end
                    2: begin
                        if (!mem_rd_n) width++;
                        else begin
                            rise_now = 1;
                            check(width == cur.w, "R4/R5", "strobe width", width, cur.w);
                            check(rd_valid == 1'b1, "R6", "valid pulse", int'(rd_valid), 1);
                            check(rd_data == cur.d, "R6", "read data", int'(rd_data), int'(cur.d));
                            since = 1;
                            have_prev = 1;
                            prev_min = cur.rh + cur.ic + 1;
                            if (!mem_sel_n) begin
                                hold_n = 1;
                                phase = 3;
                            end else begin
                                check(cur.rh == 0, "R7", "hold cycles", 0, cur.rh);
                                phase = 0;
                            end
                        end
                    end
                    3: begin
                        since++;
                        if (!mem_sel_n) begin
                            hold_n++;
                            check(mem_addr == cur.a, "R7", "address held", int'(mem_addr), int'(cur.a));
                        end else begin
                            check(hold_n == cur.rh, "R7", "hold cycles", hold_n, cur.rh);
                            phase = 0;
                        end
                    end
                    default: phase = 0;
                endcase
                if (rd_valid && !rise_now) begin
                    errors++;
                    $display("FAIL R6 stray valid: actual=1 expected=0");
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        check(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
        check(mem_sel_n && mem_rd_n, "R1", "bus idle in reset", int'({mem_sel_n, mem_rd_n}), 3);
        check(rd_valid == 1'b0, "R1", "valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(req_ready && mem_sel_n && mem_rd_n && !rd_valid, "R1", "after reset", 0, 1);

        do_read(24'h001234, 3, 2, 1, 0, -1);   // R4 R7 R8 basic
        do_read(24'h00ABCD, 0, 0, 0, 0, -1);   // R4 zero wait -> 1
        do_read(24'h0F0F0F, 1, 0, 3, 0, -1);   // R8 idle only
        do_read(24'h123456, 5, 4, 0, 0, -1);   // R7 hold only
        do_read(24'hFFFFFF, 31, 31, 31, 0, -1);// max counts
        do_read(24'h00BEEF, 3, 2, 1, 31, -1);  // R9 hold field ignored
        do_read(24'h0C0FFE, 2, 1, 1, 0, 4);    // R5 ack stretch -> 7
        do_read(24'h0A0A0A, 10, 1, 0, 0, 0);   // R5 ack within wait -> 10
        do_read(24'h055555, 0, 0, 0, 17, -1);  // R9 + R10

        while (q.size() != 0 || phase != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        check(1'b1, "R2", "continuous ready/valid monitors", 0, 0);
        check(mem_sel_n && mem_rd_n && req_ready, "R2", "idle at end", 0, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule